// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-visible register file of a multi-channel DMA controller. A single-cycle 32-bit bus port addresses it by byte address. The word offset selects either a small group of global registers or one window of eight registers belonging to one channel. The transfer engine, the descriptor fetcher and the data path sit outside this block. The engine reports channel events through per-channel set inputs. It receives a one-cycle start pulse when software enables an idle channel, and a one-cycle cancel pulse whenever software writes a channel's enable bit as zero.

The per-channel control/status word mixes software-owned configuration bits with status bits owned by the engine. Writes change only the configuration bits. Reading the word returns its current value and also clears its sticky error and interrupt flags. If a read and an engine event reach the same flag in the same cycle, the event wins, so no event is lost between the read and the clear.

Top module: `dmarb_regbank`

## Requirements
- R1: After reset every register reads zero, except the two address-mask registers of every channel (window words 3 and 5), which read 0xFFFFFFFC; chStart and chCancel are low.
- R2: Byte address bits [1:0] are ignored. Word offsets 0..4 select control, maskA, maskB, srcA and srcB. Channel n occupies word offsets 8+8n .. 15+8n, holding in window order: control/status, size, source address, source mask, destination address, destination mask, descriptor pointer and software pointer.
- R3: maskA, maskB, srcA, srcB and the seven non-status channel registers are plain 32-bit read/write registers.
- R4: The global control word always reads zero; writes to it have no effect, including its pause bit (bit 0). Reads of undefined offsets (words 5..7 and windows beyond NCH) return zero, and writes to them change nothing.
- R5: A write to a channel control/status word replaces only the writable bits 0..9 and 13..15 (mask 0x0000E3FF). Bit 0 is the enable bit. Busy (bit 10), done (bit 11), error (bit 12) and the flags in bits 16..18 keep their values.
- R6: A read of a channel control/status word returns the value held before the read edge (read data is combinational in the read cycle). At that edge it clears error (bit 12), chunk interrupt (bit 16), done interrupt (bit 17) and error interrupt (bit 18). Done and busy are not affected.
- R7: A write that sets bit 0 while it was clear drives chStart[n] high for exactly the cycle after the write and clears done (bit 11). A write of bit 0 = 1 while the bit is already set gives no pulse.
- R8: Any write of bit 0 = 0 drives chCancel[n] high for exactly the cycle after the write, whatever the previous state.
- R9: evDone, evErr, evIntChunk, evIntDone and evIntErr set bits 11, 12, 16, 17 and 18 at the next edge, and bit 10 follows evBusy one cycle later. These sets win over a clearing read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the read cycle |
| evBusy | input | NCH | Engine busy level per channel |
| evDone | input | NCH | Transfer finished |
| evErr | input | NCH | Transfer error |
| evIntChunk | input | NCH | Chunk interrupt event |
| evIntDone | input | NCH | Done interrupt event |
| evIntErr | input | NCH | Error interrupt event |
| chStart | output | NCH | One-cycle start pulse |
| chCancel | output | NCH | One-cycle cancel pulse |

## Verification
The hardest case to reach is an engine event that lands in the very cycle a clearing read of the same channel word is on the bus. The bench raises an unrelated flag first, then drives the read and two event inputs from the same falling edge. It checks that the read returns the old word, that the following read shows the new flags surviving while the old one is gone, and that a third read shows them cleared. The whole word-offset space is also swept before and after writing a distinct pattern to every offset, to cover decoding, masking and dropped writes.

// File: rtl/dmarb_pkg.sv
`timescale 1ns/1ps
package dmarb_pkg;
  localparam int CH_IDX_W = 4;

  // Control/status bit positions
  localparam int B_EN      = 0;
  localparam int B_BUSY    = 10;
  localparam int B_DONE    = 11;
  localparam int B_ERR     = 12;
  localparam int B_ICHUNK  = 16;
  localparam int B_IDONE   = 17;
  localparam int B_IERR    = 18;

  localparam logic [31:0] WR_MASK    = 32'h0000_E3FF;
  localparam logic [31:0] RDCLR_MASK = (32'h1 << B_ERR) | (32'h1 << B_ICHUNK) |
                                       (32'h1 << B_IDONE) | (32'h1 << B_IERR);
  localparam logic [31:0] AM_RST     = 32'hFFFF_FFFC;

  typedef enum logic [2:0] {
    G_CTRL = 3'd0, G_MSKA = 3'd1, G_MSKB = 3'd2, G_SRCA = 3'd3, G_SRCB = 3'd4
  } glob_e;

  typedef enum logic [2:0] {
    C_CSR = 3'd0, C_SZ = 3'd1, C_SADR = 3'd2, C_SMSK = 3'd3,
    C_DADR = 3'd4, C_DMSK = 3'd5, C_DESC = 3'd6, C_SWP = 3'd7
  } chreg_e;

  typedef struct packed {
    logic                wr;
    logic                rd;
    logic                gHit;
    glob_e               gSel;
    logic                cHit;
    logic [CH_IDX_W-1:0] cIdx;
    chreg_e              cReg;
  } regStrobe_t;

  typedef struct packed {
    logic [31:0] csr;
    logic [31:0] sz;
    logic [31:0] sAdr;
    logic [31:0] sMsk;
    logic [31:0] dAdr;
    logic [31:0] dMsk;
    logic [31:0] desc;
    logic [31:0] swp;
  } chRegs_t;
endpackage

// File: rtl/dmarb_decode.sv
`timescale 1ns/1ps
module dmarb_decode import dmarb_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int NCH       = 2,
  parameter int CH_BASE_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output regStrobe_t        stb
);
  localparam int WOFF_W  = ADDR_W - 2;
  localparam int WIN_LOG = 3;
  localparam logic [WOFF_W-1:0] BASE_L = WOFF_W'(CH_BASE_W);
  localparam logic [WOFF_W-1:0] NCH_L  = WOFF_W'(NCH);
  localparam logic [WOFF_W-1:0] NGLB_L = WOFF_W'(5);

  logic [WOFF_W-1:0] wOff, relOff, relIdx;

  assign wOff   = busAddr[ADDR_W-1:2];
  assign relOff = wOff - BASE_L;
  assign relIdx = relOff >> WIN_LOG;

  always_comb begin
    stb      = '0;
    stb.wr   = busWr;
    stb.rd   = busRd;
    stb.gHit = (wOff < NGLB_L) && (wOff < BASE_L);
    stb.gSel = glob_e'(wOff[2:0]);
    stb.cHit = (wOff >= BASE_L) && (relIdx < NCH_L);
    stb.cIdx = CH_IDX_W'(relIdx);
    stb.cReg = chreg_e'(relOff[WIN_LOG-1:0]);
  end
endmodule

// File: rtl/dmarb_regs.sv
`timescale 1ns/1ps
module dmarb_regs import dmarb_pkg::*; #(
  parameter int NCH = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            stb,
  input  logic [31:0]           wData,
  input  logic [NCH-1:0]        evBusy,
  input  logic [NCH-1:0]        evDone,
  input  logic [NCH-1:0]        evErr,
  input  logic [NCH-1:0]        evIntChunk,
  input  logic [NCH-1:0]        evIntDone,
  input  logic [NCH-1:0]        evIntErr,
  output logic [31:0]           rData,
  output logic [NCH-1:0]        chStart,
  output logic [NCH-1:0]        chCancel,
  output logic [NCH-1:0][31:0]  csrView
);
  // Global registers; the control word holds no state
  logic [31:0] mskA, mskB, srcA, srcB, gRd;
  logic        gWr;

  assign gWr = stb.wr && stb.gHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mskA <= '0;
      mskB <= '0;
      srcA <= '0;
      srcB <= '0;
    end else if (gWr) begin
      case (stb.gSel)
        G_MSKA:  mskA <= wData;
        G_MSKB:  mskB <= wData;
        G_SRCA:  srcA <= wData;
        G_SRCB:  srcB <= wData;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (stb.gSel)
      G_MSKA:  gRd = mskA;
      G_MSKB:  gRd = mskB;
      G_SRCA:  gRd = srcA;
      G_SRCB:  gRd = srcB;
      default: gRd = '0;
    endcase
  end

  // Per-channel windows
  logic [NCH-1:0][31:0] chRd;

  for (genvar i = 0; i < NCH; i++) begin : gCh
    chRegs_t     r;
    logic [31:0] csrNxt, setBits;
    logic        sel, wrC, rdC, csrWr, csrRd, startNow, cancelNow;
    logic        startQ, cancelQ;

    assign sel       = stb.cHit && (stb.cIdx == CH_IDX_W'(i));
    assign wrC       = sel && stb.wr;
    assign rdC       = sel && stb.rd && !stb.wr;
    assign csrWr     = wrC && (stb.cReg == C_CSR);
    assign csrRd     = rdC && (stb.cReg == C_CSR);
    assign startNow  = csrWr && !r.csr[B_EN] && wData[B_EN];
    assign cancelNow = csrWr && !wData[B_EN];

    always_comb begin
      setBits = '0;
      setBits[B_DONE]   = evDone[i];
      setBits[B_ERR]    = evErr[i];
      setBits[B_ICHUNK] = evIntChunk[i];
      setBits[B_IDONE]  = evIntDone[i];
      setBits[B_IERR]   = evIntErr[i];

      csrNxt = r.csr;
      if (csrWr)      csrNxt = (r.csr & ~WR_MASK) | (wData & WR_MASK);
      else if (csrRd) csrNxt = r.csr & ~RDCLR_MASK;
      if (startNow)   csrNxt[B_DONE] = 1'b0;
      csrNxt         = csrNxt | setBits;
      csrNxt[B_BUSY] = evBusy[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        r       <= '0;
        r.sMsk  <= AM_RST;
        r.dMsk  <= AM_RST;
        startQ  <= 1'b0;
        cancelQ <= 1'b0;
      end else begin
        r.csr   <= csrNxt;
        startQ  <= startNow;
        cancelQ <= cancelNow;
        if (wrC) begin
          case (stb.cReg)
            C_SZ:    r.sz   <= wData;
            C_SADR:  r.sAdr <= wData;
            C_SMSK:  r.sMsk <= wData;
            C_DADR:  r.dAdr <= wData;
            C_DMSK:  r.dMsk <= wData;
            C_DESC:  r.desc <= wData;
            C_SWP:   r.swp  <= wData;
            default: ;
          endcase
        end
      end
    end

    always_comb begin
      case (stb.cReg)
        C_CSR:   chRd[i] = r.csr;
        C_SZ:    chRd[i] = r.sz;
        C_SADR:  chRd[i] = r.sAdr;
        C_SMSK:  chRd[i] = r.sMsk;
        C_DADR:  chRd[i] = r.dAdr;
        C_DMSK:  chRd[i] = r.dMsk;
        C_DESC:  chRd[i] = r.desc;
        default: chRd[i] = r.swp;
      endcase
    end

    assign chStart[i]  = startQ;
    assign chCancel[i] = cancelQ;
    assign csrView[i]  = r.csr;
  end

  always_comb begin
    rData = '0;
    if (stb.rd) begin
      if (stb.gHit) rData = gRd;
      for (int k = 0; k < NCH; k++) begin
        if (stb.cHit && (stb.cIdx == CH_IDX_W'(k))) rData = chRd[k];
      end
    end
  end
endmodule

// File: rtl/dmarb_regbank.sv
`timescale 1ns/1ps
module dmarb_regbank import dmarb_pkg::*; #(
  parameter int NCH       = 2,
  parameter int ADDR_W    = 8,
  parameter int CH_BASE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [NCH-1:0]    evBusy,
  input  logic [NCH-1:0]    evDone,
  input  logic [NCH-1:0]    evErr,
  input  logic [NCH-1:0]    evIntChunk,
  input  logic [NCH-1:0]    evIntDone,
  input  logic [NCH-1:0]    evIntErr,
  output logic [NCH-1:0]    chStart,
  output logic [NCH-1:0]    chCancel
);
  regStrobe_t           stb;
  logic [NCH-1:0][31:0] csrView;

  dmarb_decode #(.ADDR_W(ADDR_W), .NCH(NCH), .CH_BASE_W(CH_BASE_W)) uDec (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .stb(stb)
  );

  dmarb_regs #(.NCH(NCH)) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .wData(busWdata),
    .evBusy(evBusy), .evDone(evDone), .evErr(evErr),
    .evIntChunk(evIntChunk), .evIntDone(evIntDone), .evIntErr(evIntErr),
    .rData(busRdata), .chStart(chStart), .chCancel(chCancel),
    .csrView(csrView)
  );
endmodule

// File: rtl/dmarb_chk.sv
`timescale 1ns/1ps
module dmarb_chk import dmarb_pkg::*; #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWr,
  input logic                 busRd,
  input logic [31:0]          busRdata,
  input logic [NCH-1:0]       evBusy,
  input logic [NCH-1:0]       evErr,
  input logic [NCH-1:0]       chStart,
  input logic [NCH-1:0]       chCancel,
  input logic [NCH-1:0][31:0] csrView
);
  a_r4_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[ADDR_W-1:2] == '0) |-> busRdata == 32'h0);

  a_r7_one_start: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chStart));

  a_r7_start_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    (|chStart) |-> $past(busWr));

  for (genvar i = 0; i < NCH; i++) begin : gChk
    a_r7_start_sees_enable: assert property (@(posedge clk) disable iff (!rstN)
      chStart[i] |-> csrView[i][B_EN]);

    a_r8_cancel_sees_disable: assert property (@(posedge clk) disable iff (!rstN)
      chCancel[i] |-> !csrView[i][B_EN]);

    a_r9_err_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      evErr[i] |=> csrView[i][B_ERR]);

    a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rstN)
      evBusy[i] |=> csrView[i][B_BUSY]);

    a_r9_busy_fall: assert property (@(posedge clk) disable iff (!rstN)
      !evBusy[i] |=> !csrView[i][B_BUSY]);
  end
endmodule

bind dmarb_regbank dmarb_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busRdata(busRdata), .evBusy(evBusy), .evErr(evErr),
  .chStart(chStart), .chCancel(chCancel), .csrView(csrView)
);

// File: tb/tb_dmarb_regbank.sv
`timescale 1ns/1ps
module tb_dmarb_regbank;
  localparam int NCH = 2;
  localparam int AW  = 8;
  localparam logic [31:0] WMASK = 32'h0000_E3FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0, busRdata;
  logic [NCH-1:0] evBusy = '0, evDone = '0, evErr = '0;
  logic [NCH-1:0] evIntChunk = '0, evIntDone = '0, evIntErr = '0;
  logic [NCH-1:0] chStart, chCancel;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [31:0] sh [64];
  logic [31:0] v;

  always #4 clk = ~clk;

  dmarb_regbank #(.NCH(NCH), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .evBusy(evBusy), .evDone(evDone),
    .evErr(evErr), .evIntChunk(evIntChunk), .evIntDone(evIntDone),
    .evIntErr(evIntErr), .chStart(chStart), .chCancel(chCancel)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // 0 undefined, 1 global control, 2 plain register, 3 channel control/status
  function automatic int kindOf(input int off);
    if (off == 0) return 1;
    if (off < 5) return 2;
    if (off < 8) return 0;
    if (off < 8 + 8 * NCH) return ((off - 8) % 8 == 0) ? 3 : 2;
    return 0;
  endfunction

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    busAddr = AW'(off * 4); busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdRaw(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: pulses idle after reset
    chk("R1 start", 32'(chStart), 32'h0);
    chk("R1 cancel", 32'(chCancel), 32'h0);

    for (int o = 0; o < 64; o++) begin
      sh[o] = 32'h0;
      if (kindOf(o) == 2 && o >= 8 && (((o - 8) % 8 == 3) || ((o - 8) % 8 == 5)))
        sh[o] = 32'hFFFF_FFFC;
    end
    // R1/R2: reset sweep of the full offset space
    for (int o = 0; o < 64; o++) begin
      rdRaw(AW'(o * 4), v);
      chk("R1 reset value", v, sh[o]);
    end

    // R2/R3/R4/R5: write a distinct pattern everywhere, then read back
    for (int o = 0; o < 64; o++) begin
      logic [31:0] p;
      p = 32'(o + 1) * 32'h9E37_79B9;
      wr(o, p);
      case (kindOf(o))
        2: sh[o] = p;
        3: sh[o] = p & WMASK;
        default: ;
      endcase
    end
    for (int o = 0; o < 64; o++) begin
      rdRaw(AW'(o * 4), v);
      chk("R3 R4 R5 sweep readback", v, sh[o]);
    end

    // R4: pause bit and undefined offsets
    wr(0, 32'h0000_0001);
    rdRaw(8'h00, v); chk("R4 pause ignored", v, 32'h0);
    wr(5, 32'hDEAD_BEEF);
    rdRaw(8'h14, v); chk("R4 undefined word5", v, 32'h0);
    wr(24, 32'hDEAD_BEEF);
    rdRaw(8'h60, v); chk("R4 undefined window", v, 32'h0);

    // R8 / R7: cancel and start pulses on channel 0
    wr(8, 32'h0);
    chk("R8 cancel pulse", 32'(chCancel), 32'h1);
    chk("R8 no start", 32'(chStart), 32'h0);
    @(negedge clk);
    chk("R8 cancel one cycle", 32'(chCancel), 32'h0);
    wr(8, 32'h1);
    chk("R7 start pulse", 32'(chStart), 32'h1);
    @(negedge clk);
    chk("R7 start one cycle", 32'(chStart), 32'h0);
    wr(8, 32'h1);
    chk("R7 no restart when enabled", 32'(chStart), 32'h0);
    wr(8, 32'h0);
    chk("R8 cancel again", 32'(chCancel), 32'h1);

    // R9 / R6: events then clearing reads
    @(negedge clk); evIntChunk[0] = 1'b1; evDone[0] = 1'b1;
    @(negedge clk); evIntChunk[0] = 1'b0; evDone[0] = 1'b0;
    rdRaw(8'h20, v); chk("R9 event bits set", v, 32'h0001_0800);
    rdRaw(8'h20, v); chk("R6 read clears flags keeps done", v, 32'h0000_0800);

    // R9 priority: events in the cycle of a clearing read
    @(negedge clk); evIntChunk[0] = 1'b1;
    @(negedge clk); evIntChunk[0] = 1'b0;
    @(negedge clk);
    busAddr = 8'h20; busRd = 1'b1; evErr[0] = 1'b1; evIntDone[0] = 1'b1;
    #1 v = busRdata;
    chk("R6 read returns pre-edge value", v, 32'h0001_0800);
    @(negedge clk);
    busRd = 1'b0; evErr[0] = 1'b0; evIntDone[0] = 1'b0;
    rdRaw(8'h20, v); chk("R9 set wins over read clear", v, 32'h0002_1800);
    rdRaw(8'h20, v); chk("R6 second read clears", v, 32'h0000_0800);

    // R7: start clears done
    wr(8, 32'h1);
    chk("R7 start pulse", 32'(chStart), 32'h1);
    rdRaw(8'h20, v); chk("R7 done cleared by start", v, 32'h0000_0001);

    // R5 / R9: busy on channel 1 survives writes
    @(negedge clk); evBusy[1] = 1'b1;
    wr(16, 32'hFFFF_FFFF);
    rdRaw(8'h40, v); chk("R5 write mask with busy", v, 32'h0000_E7FF);
    wr(16, 32'h0);
    chk("R8 cancel ch1", 32'(chCancel), 32'h2);
    rdRaw(8'h40, v); chk("R5 busy kept by write", v, 32'h0000_0400);
    @(negedge clk); evBusy[1] = 1'b0;
    rdRaw(8'h40, v); chk("R9 busy follows input", v, 32'h0);

    // R2: byte offset bits ignored
    @(negedge clk);
    busAddr = 8'h27; busWdata = 32'h1234_5678; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
    rdRaw(8'h24, v); chk("R2 low bits ignored on write", v, 32'h1234_5678);
    rdRaw(8'h26, v); chk("R2 low bits ignored on read", v, 32'h1234_5678);

    finish();
  end
endmodule